// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block translates a virtual address into a physical address by walking a flat, one-level page table that sits in a word-addressed memory. A request carries a virtual address. The low 12 bits are the page offset, for 4 KB pages, and the upper bits are the virtual page number. The walker adds the page number, counted in words, to a table base register and reads that single-word table entry through a synchronous read port. If the entry's valid flag is set, the walker joins the entry's frame number to the unchanged offset. If the flag is clear, it reports a page fault. When the request asks for it, the walker makes a second read at the physical address and returns the word found there. A full data fetch therefore costs exactly two memory reads.

The walker takes one request at a time. It drops its ready output from the accepting edge until the walk ends, so it never sees an overlapping request. The table base is loaded through its own write strobe. Only walks accepted after that write use the new value.

Top module: `pt_walker`

## Requirements
- R1: While reset is held and in the cycle after it, `req_ready` is 1, `done` is 0 and `mem_rd_en` is 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. In the next cycle the walker asserts `mem_rd_en` with `mem_addr` equal to the table base plus `req_va[31:12]`, zero-extended to a word address.
- R3: A table entry is valid when bit 31 is 1. Its frame number is bits 19:0. For a valid entry, `pa` is the frame number in bits 31:12 and `req_va[11:0]` in bits 11:0. For example, base 0x100 and address 0x10020 read entry 0x110, and an entry frame of 0x22 gives `pa` 0x22020. In lookup-only mode (`req_fetch`=0), `done` rises in the cycle after the second edge following the accepting edge.
- R4: An entry with bit 31 equal to 0 asserts `fault` together with `done`. It makes no second read, even when `req_fetch` is 1. `done` comes at the same time as in R3.
- R5: With `req_fetch`=1 and a valid entry, the walker makes exactly one more read, at address `pa`. It presents the returned word on `data` with `done`, in the cycle after the fourth edge following the accepting edge. Two reads are never issued in consecutive cycles.
- R6: `req_ready` is 0 from the accepting edge through the `done` cycle. A `req_valid` that is held during that time is not accepted and produces no result.
- R7: A base write (`ptbr_we`=1) takes effect at the next edge. A walk accepted on that same edge, or already in progress, uses the old base. Walks accepted later use the new base.
- R8: `done` lasts exactly one cycle, and `fault` is never 1 when `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ptbr_we | input | 1 | Table base write strobe |
| ptbr_wdata | input | 32 | New table base (word address) |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_va | input | 32 | Virtual address to translate |
| req_fetch | input | 1 | Also read the data word at the physical address |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | 32 | Memory word address |
| mem_rdata | input | 32 | Read data, valid the cycle after the strobe |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Page fault, valid with done |
| pa | output | 32 | Physical address, valid with done when no fault |
| data | output | 32 | Fetched word, valid with done in fetch mode |

## Verification
A wrong base snapshot or page-number add shows up at the first read, in the cycle after acceptance, as a bad `mem_addr`. A corrupt saved offset or frame shows up at `done` as a bad `pa`, and in fetch mode two cycles earlier as a bad second read address. A controller stuck in or skipping a state changes the count of reads per walk and the number of cycles before `done`. It can also produce a result with no request behind it, or no result at all. The bench checks every one of these on each completion.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PTE_RD,
        ST_PTE_WAIT,
        ST_DATA_RD,
        ST_DATA_WAIT,
        ST_DONE
    } walk_state_t;

    typedef struct packed {
        logic fetch;
        logic fault;
    } walk_flags_t;

    function automatic logic is_read_state(walk_state_t s);
        return (s == ST_PTE_RD) || (s == ST_DATA_RD);
    endfunction

endpackage

// File: rtl/ptw_base_reg.sv
module ptw_base_reg #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] wdata,
    output logic [AW-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (we) q <= wdata;
    end
endmodule

// File: rtl/ptw_addr.sv
module ptw_addr #(
    parameter int VPN_W   = 20,
    parameter int OFF_W   = 12,
    parameter int FRAME_W = 20,
    parameter int MEM_AW  = 32
) (
    input  logic [VPN_W-1:0]   vpn,
    input  logic [MEM_AW-1:0]  base,
    input  logic [FRAME_W-1:0] frame,
    input  logic [OFF_W-1:0]   off,
    output logic [MEM_AW-1:0]  entry_addr,
    output logic [MEM_AW-1:0]  pa_addr
);
    localparam int PA_W = FRAME_W + OFF_W;

    logic [MEM_AW-1:0] vpn_ext;
    logic [PA_W-1:0]   pa_full;

    assign vpn_ext    = MEM_AW'(vpn);
    assign entry_addr = base + vpn_ext;
    assign pa_full    = {frame, off};

    generate
        if (PA_W < MEM_AW) begin : g_pad
            assign pa_addr = {{(MEM_AW-PA_W){1'b0}}, pa_full};
        end else begin : g_fit
            assign pa_addr = pa_full[MEM_AW-1:0];
        end
    endgenerate
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
    import pt_walker_pkg::*;
#(
    parameter int OFF_W  = 12,
    parameter int MEM_AW = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_fetch,
    input  logic [OFF_W-1:0]  req_off,
    output logic              req_ready,
    input  logic [MEM_AW-1:0] entry_addr,
    input  logic              pte_ok,
    input  logic [MEM_AW-1:0] pa_addr,
    output logic [OFF_W-1:0]  off_q,
    output logic              mem_rd_en,
    output logic [MEM_AW-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic              fault,
    output logic [MEM_AW-1:0] pa,
    output logic [DATA_W-1:0] data
);
    walk_state_t       state;
    walk_flags_t       flags;
    logic [MEM_AW-1:0] addr_q;
    logic [MEM_AW-1:0] pa_q;
    logic [DATA_W-1:0] data_q;
    logic              accept;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign mem_rd_en = is_read_state(state);
    assign mem_addr  = addr_q;
    assign done      = (state == ST_DONE);
    assign fault     = done && flags.fault;
    assign pa        = pa_q;
    assign data      = data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            flags  <= '0;
            addr_q <= '0;
            pa_q   <= '0;
            data_q <= '0;
            off_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    addr_q      <= entry_addr;
                    off_q       <= req_off;
                    flags.fetch <= req_fetch;
                    flags.fault <= 1'b0;
                    data_q      <= '0;
                    state       <= ST_PTE_RD;
                end
                ST_PTE_RD:   state <= ST_PTE_WAIT;
                ST_PTE_WAIT: begin
                    if (!pte_ok) begin
                        flags.fault <= 1'b1;
                        state       <= ST_DONE;
                    end else begin
                        pa_q <= pa_addr;
                        if (flags.fetch) begin
                            addr_q <= pa_addr;
                            state  <= ST_DATA_RD;
                        end else begin
                            state <= ST_DONE;
                        end
                    end
                end
                ST_DATA_RD:   state <= ST_DATA_WAIT;
                ST_DATA_WAIT: begin
                    data_q <= mem_rdata;
                    state  <= ST_DONE;
                end
                ST_DONE:  state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
    parameter int VA_W      = 32,
    parameter int OFF_W     = 12,
    parameter int FRAME_W   = 20,
    parameter int MEM_AW    = 32,
    parameter int DATA_W    = 32,
    parameter int VALID_BIT = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ptbr_we,
    input  logic [MEM_AW-1:0] ptbr_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_va,
    input  logic              req_fetch,
    output logic              mem_rd_en,
    output logic [MEM_AW-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic              fault,
    output logic [MEM_AW-1:0] pa,
    output logic [DATA_W-1:0] data
);
    localparam int VPN_W = VA_W - OFF_W;

    logic [MEM_AW-1:0] base_q;
    logic [MEM_AW-1:0] entry_addr;
    logic [MEM_AW-1:0] pa_addr;
    logic [OFF_W-1:0]  off_q;

    ptw_base_reg #(.AW(MEM_AW)) u_base (
        .clk   (clk),
        .rst   (rst),
        .we    (ptbr_we),
        .wdata (ptbr_wdata),
        .q     (base_q)
    );

    ptw_addr #(
        .VPN_W(VPN_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W), .MEM_AW(MEM_AW)
    ) u_addr (
        .vpn        (req_va[VA_W-1:OFF_W]),
        .base       (base_q),
        .frame      (mem_rdata[FRAME_W-1:0]),
        .off        (off_q),
        .entry_addr (entry_addr),
        .pa_addr    (pa_addr)
    );

    ptw_ctrl #(
        .OFF_W(OFF_W), .MEM_AW(MEM_AW), .DATA_W(DATA_W)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_fetch  (req_fetch),
        .req_off    (req_va[OFF_W-1:0]),
        .req_ready  (req_ready),
        .entry_addr (entry_addr),
        .pte_ok     (mem_rdata[VALID_BIT]),
        .pa_addr    (pa_addr),
        .off_q      (off_q),
        .mem_rd_en  (mem_rd_en),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata),
        .done       (done),
        .fault      (fault),
        .pa         (pa),
        .data       (data)
    );
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_ready,
    input logic mem_rd_en,
    input logic done,
    input logic fault
);
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (req_ready && !done && !mem_rd_en));

    p_read_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> mem_rd_en);

    p_reads_spaced_r5: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> !mem_rd_en);

    p_busy_after_accept_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    p_done_not_ready_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> !req_ready);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_fault_with_done_r8: assert property (@(posedge clk) disable iff (rst)
        fault |-> done);

    p_no_read_at_done_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_rd_en);
endmodule

bind pt_walker pt_walker_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .mem_rd_en (mem_rd_en),
    .done      (done),
    .fault     (fault)
);

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ptbr_we = 1'b0;
    logic [31:0] ptbr_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic        req_fetch = 1'b0;
    logic        mem_rd_en;
    logic [31:0] mem_addr;
    logic [31:0] mem_rdata = '0;
    logic        done, fault;
    logic [31:0] pa, data;

    always #10 clk = ~clk;

    pt_walker u_dut (
        .clk(clk), .rst(rst), .ptbr_we(ptbr_we), .ptbr_wdata(ptbr_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
        .req_fetch(req_fetch), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .done(done), .fault(fault), .pa(pa), .data(data)
    );

    logic [31:0] mem [logic [31:0]];

    function automatic logic [31:0] rd(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return 32'h0;
    endfunction

    always @(posedge clk) if (mem_rd_en) mem_rdata <= rd(mem_addr);

    typedef struct {
        logic [31:0] entry;
        logic [31:0] pa;
        logic [31:0] data;
        logic        fault;
        logic        fetch;
        int          acc;
    } exp_t;

    exp_t sb[$];
    int total = 0, fails = 0, cyc = 0, done_cnt = 0, walks = 0;
    int nreads = 0;
    logic [31:0] first_addr, second_addr;
    logic prev_done = 1'b0;
    logic [31:0] base_model = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_base(input logic [31:0] b);
        ptbr_we = 1'b1; ptbr_wdata = b;
        @(negedge clk);
        ptbr_we = 1'b0;
        base_model = b;
    endtask

    // driver: accepts one walk and pushes its expected result
    task automatic start_walk(input logic [31:0] va, input bit fetch, input bit wr, input logic [31:0] nb);
        exp_t e;
        logic [31:0] pte;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_va = va; req_fetch = fetch;
        if (wr) begin ptbr_we = 1'b1; ptbr_wdata = nb; end
        e.entry = base_model + {12'h0, va[31:12]};
        pte     = rd(e.entry);
        e.fault = !pte[31];
        e.pa    = {pte[19:0], va[11:0]};
        e.data  = rd(e.pa);
        e.fetch = fetch;
        @(negedge clk);
        req_valid = 1'b0;
        ptbr_we   = 1'b0;
        if (wr) base_model = nb;
        e.acc = cyc;
        walks++;
        sb.push_back(e);
    endtask

    // monitor: compares each completion against the scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_done && done) chk(0, "R8 done longer than one cycle", 1, 0);
            if (fault && !done)    chk(0, "R8 fault without done", 1, 0);
            if (mem_rd_en) begin
                if (nreads == 0) first_addr = mem_addr;
                else             second_addr = mem_addr;
                nreads++;
            end
            if (done) begin
                done_cnt++;
                if (sb.size() == 0) begin
                    chk(0, "R6 result with no accepted request", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(first_addr == e.entry, "R2 entry address", first_addr, e.entry);
                    chk(fault == e.fault, "R4 fault flag", {31'h0, fault}, {31'h0, e.fault});
                    chk(!req_ready, "R6 ready low at done", {31'h0, req_ready}, 0);
                    if (!e.fault)
                        chk(pa == e.pa, "R3 physical address", pa, e.pa);
                    if (e.fault || !e.fetch) begin
                        chk(nreads == 1, "R4 one read only", nreads, 1);
                        chk(cyc - e.acc == 2, "R3 lookup latency", cyc - e.acc, 2);
                    end else begin
                        chk(nreads == 2, "R5 two reads", nreads, 2);
                        chk(second_addr == e.pa, "R5 data read address", second_addr, e.pa);
                        chk(data == e.data, "R5 fetched data", data, e.data);
                        chk(cyc - e.acc == 4, "R5 fetch latency", cyc - e.acc, 4);
                    end
                end
                nreads = 0;
            end
            prev_done = done;
        end
    end

    initial begin
        mem[32'h110]   = 32'h8000_0022;
        mem[32'h120]   = 32'h8000_0045;
        mem[32'h130]   = 32'h0000_0078;
        mem[32'h210]   = 32'h8000_0045;
        mem[32'h22020] = 32'h0000_2222;
        mem[32'h45000] = 32'h0000_5555;
        mem[32'h45020] = 32'h0000_6666;
        mem[32'h10020] = 32'h0000_4444;

        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready in reset", {31'h0, req_ready}, 1);
        chk(done == 1'b0, "R1 done in reset", {31'h0, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", {31'h0, req_ready}, 1);
        chk(mem_rd_en == 1'b0, "R1 no read after reset", {31'h0, mem_rd_en}, 0);
        chk(done == 1'b0, "R1 no done after reset", {31'h0, done}, 0);

        write_base(32'h100);
        start_walk(32'h0001_0020, 1'b0, 1'b0, 0);   // R2 R3: entry 0x110 -> 0x22020
        start_walk(32'h0001_0020, 1'b1, 1'b0, 0);   // R5: data 0x2222
        start_walk(32'h0002_0abc, 1'b0, 1'b0, 0);   // R3: 0x45abc
        start_walk(32'h0002_0000, 1'b1, 1'b0, 0);   // R5: data 0x5555
        start_walk(32'h0003_0abc, 1'b1, 1'b0, 0);   // R4: invalid entry, no data read
        start_walk(32'h0005_5000, 1'b0, 1'b0, 0);   // R4: zero entry

        // R6: requests held while busy are not taken
        start_walk(32'h0001_0020, 1'b0, 1'b0, 0);
        req_valid = 1'b1; req_va = 32'h0002_0000; req_fetch = 1'b1;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk(done_cnt == walks, "R6 held request ignored", done_cnt, walks);

        // R7: write on the accepting edge uses the old base
        start_walk(32'h0001_0020, 1'b0, 1'b1, 32'h200);
        start_walk(32'h0001_0020, 1'b1, 1'b0, 0);   // new base: entry 0x210 -> 0x45020
        // R7: write during a walk does not affect it
        start_walk(32'h0001_0020, 1'b0, 1'b0, 0);
        write_base(32'h100);
        start_walk(32'h0001_0020, 1'b0, 1'b0, 0);   // entry 0x110 again

        while (sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(done_cnt == walks, "R8 one done per walk", done_cnt, walks);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", sb.size(), 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule